// File: doc/BRIEF.md
# Low-Frequency Watchdog with Early-Warning Interrupt

This block is a watchdog that counts rising edges of a slow 32.768 kHz clock on a 20-bit count. The slow clock comes from one of two sources, an on-chip oscillator or an external one. Each source is synchronized into the fast system clock domain, and its rising edges become single-cycle ticks. A configuration bit chooses the source. The choice is applied only on a cycle in which neither source produces an edge, so a switch never splits or doubles a tick.

Two 8-bit thresholds are compared with the upper eight bits of the count, so one threshold step is 4096 ticks (125 ms). The lower threshold is an early warning: it raises an interrupt flag that software clears by writing 1. The higher threshold ends the run. It emits a reset pulse of fixed length and records that the watchdog caused it. A scope bit chooses whether the pulse requests a reset of the whole system or of the CPU alone. The watchdog's own registers are never cleared by the pulse.

Software keeps the watchdog from firing by writing a clear code. This restarts the count and drops any pending warning.

Top module: `lf_watchdog`

## Requirements
- R1: After reset the count is 0, the interrupt, both reset requests and the cause flag are 0, the watchdog is disabled and the internal source is selected.
- R2: While enabled (configuration address 0, bit 0 = 1) the count rises by exactly one per rising edge of the selected slow clock and wraps modulo 2^20. While disabled it is held at 0.
- R3: Configuration bit 7 selects the external slow clock when 1 and the internal one when 0. Edges on the unselected source do not change the count.
- R4: A write of 0x5A to address 3 zeroes the count and the interrupt flag in the following cycle. Any other value written to address 3 leaves the count unchanged.
- R5: The interrupt flag is set when count bits 19:12 equal the interrupt threshold (address 1). It stays set until a write to address 4 with bit 0 = 1. A write to address 4 with bit 0 = 0 leaves it set.
- R6: Within one count run the interrupt flag is raised at most once. After it is cleared it does not return while count bits 19:12 still equal the threshold.
- R7: When count bits 19:12 equal the reset threshold (address 2), a reset request pulse of exactly 16 cycles follows and the count restarts from 0. The pulse appears on cpu_rst_req when configuration bit 1 = 1 and on sys_rst_req when that bit = 0, never on both.
- R8: Each watchdog reset sets the cause flag. The flag survives the reset pulse and is cleared only by a write to address 4 with bit 1 = 1.
- R9: A threshold of 0 disables its stage: no interrupt, or no reset request, however far the count runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| lf_int_clk | input | 1 | Internal 32.768 kHz clock, asynchronous |
| lf_ext_clk | input | 1 | External 32.768 kHz clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 configuration, 1 interrupt threshold, 2 reset threshold, 3 clear, 4 flag clear |
| wr_data | input | 8 | Register write data |
| count | output | 20 | Current tick count |
| wdt_irq | output | 1 | Early-warning interrupt flag |
| sys_rst_req | output | 1 | Whole-system reset request pulse |
| cpu_rst_req | output | 1 | CPU-only reset request pulse |
| rst_cause | output | 1 | Set when the watchdog has issued a reset |

## Verification
A slow-clock rising edge moves the count on the third system clock edge after it, because of two synchronizer stages and an edge register. The bench therefore holds each slow-clock level for at least two cycles and reads the count several cycles after the last edge. Register writes and clear codes take effect on the next edge, and the bench samples on the falling edge after that. A threshold hit reaches the interrupt or reset outputs one edge after the count gets there. The reset pulse is measured by counting high cycles on each request line over a window that is longer than the pulse.

// File: rtl/lfwd_pkg.sv
package lfwd_pkg;
   typedef enum logic [2:0] {
      A_CFG     = 3'd0,
      A_INT_THR = 3'd1,
      A_RST_THR = 3'd2,
      A_KICK    = 3'd3,
      A_FLAGS   = 3'd4
   } lfwd_addr_e;

   localparam int CFG_EN_BIT    = 0;
   localparam int CFG_SCOPE_BIT = 1;
   localparam int CFG_SRC_BIT   = 7;
   localparam int FL_IRQ_BIT    = 0;
   localparam int FL_CAUSE_BIT  = 1;

   typedef struct packed {
      logic src_ext;
      logic cpu_only;
      logic en;
   } lfwd_cfg_t;
endpackage

// File: rtl/lfwd_tick_sel.sv
module lfwd_tick_sel
   import lfwd_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lf_int_clk,
   input  logic lf_ext_clk,
   input  logic sel_ext,
   output logic tick
);
   localparam int NSRC = 2;

   logic [NSRC-1:0] raw;
   logic [NSRC-1:0] edge_det;
   logic            sel_q;

   assign raw = {lf_ext_clk, lf_int_clk};

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic [SYNC_STAGES-1:0] sh;
      logic                   prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
         end else begin
            if (SYNC_STAGES > 1)
               sh <= {sh[SYNC_STAGES-2:0], raw[g]};
            else
               sh[0] <= raw[g];
            prev <= sh[SYNC_STAGES-1];
         end
      end
      assign edge_det[g] = sh[SYNC_STAGES-1] & ~prev;
   end

   // source change is taken only on a cycle without any edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= 1'b0;
      else if (edge_det == '0)
         sel_q <= sel_ext;
   end

   assign tick = sel_q ? edge_det[1] : edge_det[0];
endmodule

// File: rtl/lfwd_regs.sv
module lfwd_regs
   import lfwd_pkg::*;
#(
   parameter int         DATA_W     = 8,
   parameter int         THR_W      = 8,
   parameter logic [7:0] CLEAR_CODE = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output lfwd_cfg_t         cfg,
   output logic [THR_W-1:0]  int_thr,
   output logic [THR_W-1:0]  rst_thr,
   output logic              kick,
   output logic              clr_irq,
   output logic              clr_cause
);
   lfwd_addr_e addr;
   assign addr = lfwd_addr_e'(wr_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         int_thr <= '0;
         rst_thr <= '0;
      end else if (wr_en) begin
         case (addr)
            A_CFG: begin
               cfg.en       <= wr_data[CFG_EN_BIT];
               cfg.cpu_only <= wr_data[CFG_SCOPE_BIT];
               cfg.src_ext  <= wr_data[CFG_SRC_BIT];
            end
            A_INT_THR: int_thr <= wr_data[THR_W-1:0];
            A_RST_THR: rst_thr <= wr_data[THR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      kick      = wr_en && (addr == A_KICK) && (wr_data[7:0] == CLEAR_CODE);
      clr_irq   = wr_en && (addr == A_FLAGS) && wr_data[FL_IRQ_BIT];
      clr_cause = wr_en && (addr == A_FLAGS) && wr_data[FL_CAUSE_BIT];
   end
endmodule

// File: rtl/lfwd_core.sv
module lfwd_core #(
   parameter int CNT_W      = 20,
   parameter int THR_W      = 8,
   parameter int RST_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             cpu_only,
   input  logic [THR_W-1:0] int_thr,
   input  logic [THR_W-1:0] rst_thr,
   input  logic             kick,
   input  logic             clr_irq,
   input  logic             clr_cause,
   output logic [CNT_W-1:0] count,
   output logic             irq,
   output logic             sys_rst_req,
   output logic             cpu_rst_req,
   output logic             cause
);
   localparam int CMP_LSB = CNT_W - THR_W;
   localparam int RC_W    = $clog2(RST_CYCLES + 1);

   logic [THR_W-1:0] cnt_hi;
   logic             int_fired;
   logic [RC_W-1:0]  rst_left;
   logic             scope_q;
   logic             hit_int, hit_rst, pulsing;

   assign cnt_hi  = count[CNT_W-1:CMP_LSB];
   assign pulsing = (rst_left != '0);
   assign hit_int = en && (int_thr != '0) && (cnt_hi == int_thr) && !int_fired;
   assign hit_rst = en && (rst_thr != '0) && (cnt_hi == rst_thr) && !pulsing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (!en || kick || hit_rst)
         count <= '0;
      else if (tick)
         count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq       <= 1'b0;
         int_fired <= 1'b0;
      end else if (kick) begin
         irq       <= 1'b0;
         int_fired <= 1'b0;
      end else if (!en || hit_rst) begin
         int_fired <= 1'b0;
         if (clr_irq) irq <= 1'b0;
      end else if (hit_int) begin
         irq       <= 1'b1;
         int_fired <= 1'b1;
      end else if (clr_irq) begin
         irq <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_left <= '0;
         scope_q  <= 1'b0;
         cause    <= 1'b0;
      end else begin
         if (hit_rst) begin
            rst_left <= RC_W'(RST_CYCLES);
            scope_q  <= cpu_only;
         end else if (pulsing) begin
            rst_left <= rst_left - 1'b1;
         end
         if (hit_rst)
            cause <= 1'b1;
         else if (clr_cause)
            cause <= 1'b0;
      end
   end

   assign sys_rst_req = pulsing && !scope_q;
   assign cpu_rst_req = pulsing && scope_q;
endmodule

// File: rtl/lf_watchdog.sv
module lf_watchdog
   import lfwd_pkg::*;
#(
   parameter int         CNT_W       = 20,
   parameter int         THR_W       = 8,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         RST_CYCLES  = 16,
   parameter logic [7:0] CLEAR_CODE  = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lf_int_clk,
   input  logic              lf_ext_clk,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count,
   output logic              wdt_irq,
   output logic              sys_rst_req,
   output logic              cpu_rst_req,
   output logic              rst_cause
);
   if (THR_W > CNT_W) begin : g_bad_thr
      $error("THR_W must not exceed CNT_W");
   end
   if (DATA_W < 8 || THR_W > DATA_W) begin : g_bad_data
      $error("DATA_W must be at least 8 and hold THR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RST_CYCLES < 2) begin : g_bad_pulse
      $error("RST_CYCLES must be at least 2");
   end

   lfwd_cfg_t        cfg;
   logic [THR_W-1:0] int_thr, rst_thr;
   logic             kick, clr_irq, clr_cause, tick;

   lfwd_regs #(
      .DATA_W(DATA_W), .THR_W(THR_W), .CLEAR_CODE(CLEAR_CODE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cfg(cfg), .int_thr(int_thr), .rst_thr(rst_thr),
      .kick(kick), .clr_irq(clr_irq), .clr_cause(clr_cause)
   );

   lfwd_tick_sel #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .lf_int_clk(lf_int_clk),
      .lf_ext_clk(lf_ext_clk), .sel_ext(cfg.src_ext), .tick(tick)
   );

   lfwd_core #(
      .CNT_W(CNT_W), .THR_W(THR_W), .RST_CYCLES(RST_CYCLES)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg.en),
      .cpu_only(cfg.cpu_only), .int_thr(int_thr), .rst_thr(rst_thr),
      .kick(kick), .clr_irq(clr_irq), .clr_cause(clr_cause),
      .count(count), .irq(wdt_irq), .sys_rst_req(sys_rst_req),
      .cpu_rst_req(cpu_rst_req), .cause(rst_cause)
   );
endmodule

// File: rtl/lf_watchdog_chk.sv
module lf_watchdog_chk #(
   parameter int         CNT_W      = 20,
   parameter int         DATA_W     = 8,
   parameter logic [7:0] CLEAR_CODE = 8'h5A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [CNT_W-1:0]  count,
   input logic              wdt_irq,
   input logic              sys_rst_req,
   input logic              cpu_rst_req,
   input logic              rst_cause
);
   logic kick_w, clr_irq_w;
   assign kick_w    = wr_en && wr_addr == 3'd3 && wr_data[7:0] == CLEAR_CODE;
   assign clr_irq_w = wr_en && wr_addr == 3'd4 && wr_data[0];

   // R2: the count only steps by one or returns to zero
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1) || count == '0));

   // R4: the clear code empties the count and the warning
   p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      kick_w |=> (count == '0 && !wdt_irq));

   // R5: the warning holds until cleared
   p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_irq && !kick_w && !clr_irq_w) |=> wdt_irq);

   // R7: the two request lines never pulse together
   p_scope_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sys_rst_req && cpu_rst_req));

   // R7: a request pulse lasts more than one cycle
   p_pulse_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_req || cpu_rst_req) |=> (sys_rst_req || cpu_rst_req));

   // R8: the cause flag accompanies every request pulse
   p_cause_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_req || cpu_rst_req) |-> rst_cause);
endmodule

bind lf_watchdog lf_watchdog_chk #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .CLEAR_CODE(CLEAR_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .count(count), .wdt_irq(wdt_irq),
   .sys_rst_req(sys_rst_req), .cpu_rst_req(cpu_rst_req),
   .rst_cause(rst_cause)
);

// File: tb/lf_watchdog_test.sv
`timescale 1ns/1ps
module lf_watchdog_test;
   localparam int RST_LEN = 16;
   localparam int STEP    = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lf_int_clk = 1'b0, lf_ext_clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [19:0] count;
   logic        wdt_irq, sys_rst_req, cpu_rst_req, rst_cause;

   int tests = 0, fails = 0;
   int sys_hi = 0, cpu_hi = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lf_watchdog uut (
      .clk(clk), .rst_n(rst_n), .lf_int_clk(lf_int_clk), .lf_ext_clk(lf_ext_clk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
      .wdt_irq(wdt_irq), .sys_rst_req(sys_rst_req), .cpu_rst_req(cpu_rst_req),
      .rst_cause(rst_cause)
   );

   always @(negedge clk) begin
      if (sys_rst_req) sys_hi++;
      if (cpu_rst_req) cpu_hi++;
   end

   function automatic logic [7:0] cfg_byte(bit ext, bit cpu, bit en);
      return {ext, 5'b0, cpu, en};
   endfunction

   function automatic int next_count(int cur, bit en, bit ext, int n_int, int n_ext);
      if (!en) return 0;
      return (cur + (ext ? n_ext : n_int)) % (1 << 20);
   endfunction

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse(bit ext, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (ext) lf_ext_clk = 1'b1; else lf_int_clk = 1'b1;
         repeat (2) @(negedge clk);
         if (ext) lf_ext_clk = 1'b0; else lf_int_clk = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int model;
      bit en, ext;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      chk("R1 count", count, 0);
      chk("R1 irq", wdt_irq, 0);
      chk("R1 sys req", sys_rst_req, 0);
      chk("R1 cpu req", cpu_rst_req, 0);
      chk("R1 cause", rst_cause, 0);
      // R1/R2 disabled by default: edges do nothing
      pulse(0, 3); settle();
      chk("R1 R2 disabled default", count, 0);

      // R2 R3 R4 random run with both sources
      model = 0;
      for (int it = 0; it < 40; it++) begin
         int ni, ne;
         en  = ($urandom % 5) != 0;
         ext = $urandom % 2;
         wr(3'd0, cfg_byte(ext, 0, en));
         if (!en) model = 0;
         ni = $urandom % 6;
         ne = $urandom % 6;
         pulse(0, ni);
         pulse(1, ne);
         settle();
         model = next_count(model, en, ext, ni, ne);
         chk("R2 R3 random count", count, model);
         if (($urandom % 6) == 0) begin
            wr(3'd3, 8'h5A); model = 0;
            chk("R4 clear code", count, 0);
         end else if (($urandom % 4) == 0) begin
            wr(3'd3, 8'($urandom % 90)); // never 0x5A
            chk("R4 other value ignored", count, model);
         end
      end

      // R3 switching sources directly
      wr(3'd3, 8'h5A);
      wr(3'd0, cfg_byte(1, 0, 1));
      pulse(0, 4); settle();
      chk("R3 internal ignored when external selected", count, 0);
      pulse(1, 3); settle();
      chk("R3 external counted", count, 3);
      wr(3'd0, cfg_byte(0, 0, 1));
      pulse(1, 2); pulse(0, 1); settle();
      chk("R3 back to internal", count, 4);

      // R5 R6 R9 early warning, reset stage off
      wr(3'd3, 8'h5A);
      wr(3'd2, 8'd0);
      wr(3'd1, 8'd1);
      sys_hi = 0; cpu_hi = 0;
      pulse(0, STEP - 1); settle();
      chk("R5 no irq below threshold", wdt_irq, 0);
      pulse(0, 1); settle();
      chk("R5 irq at threshold", wdt_irq, 1);
      chk("R5 count at threshold", count, STEP);
      wr(3'd4, 8'h02);
      chk("R5 irq kept by bit0=0 write", wdt_irq, 1);
      wr(3'd4, 8'h01);
      chk("R5 irq cleared by W1C", wdt_irq, 0);
      pulse(0, 5); settle();
      chk("R6 irq not raised again", wdt_irq, 0);
      chk("R9 no reset with zero threshold", sys_hi + cpu_hi, 0);
      pulse(0, 3); wr(3'd1, 8'd0); // leave the count above the warning
      wr(3'd3, 8'h5A);
      chk("R4 clear after run", count, 0);

      // R7 R8 R9 system-scope reset, warning off
      wr(3'd2, 8'd1);
      sys_hi = 0; cpu_hi = 0;
      pulse(0, STEP); repeat (30) @(negedge clk);
      chk("R7 sys pulse length", sys_hi, RST_LEN);
      chk("R7 cpu quiet in system scope", cpu_hi, 0);
      chk("R7 count restarted", count, 0);
      chk("R8 cause set", rst_cause, 1);
      chk("R9 no irq with zero threshold", wdt_irq, 0);
      pulse(0, 2); settle();
      chk("R8 cause survives", rst_cause, 1);
      chk("R7 counting resumes", count, 2);
      wr(3'd4, 8'h02);
      chk("R8 cause cleared", rst_cause, 0);

      // R7 R8 CPU-only scope
      wr(3'd3, 8'h5A);
      wr(3'd0, cfg_byte(0, 1, 1));
      sys_hi = 0; cpu_hi = 0;
      pulse(0, STEP); repeat (30) @(negedge clk);
      chk("R7 cpu pulse length", cpu_hi, RST_LEN);
      chk("R7 sys quiet in cpu scope", sys_hi, 0);
      chk("R8 cause set cpu scope", rst_cause, 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule